// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider with Reference Divider

The block produces the two comparison pulses that a synthesizer loop compares. In the feedback path, the VCO-rate clock is divided by a total ratio of M·N + A. A dual-modulus prescaler divides by M+1 or M. A swallow counter decides how many prescaler periods use the larger modulus. A main counter counts every prescaler period and ends the full division cycle. On the last prescaler output of each cycle the block raises `fb_pulse` for one VCO clock.

A separate reference divider runs on the oscillator clock. It divides that clock by R and raises `ref_pulse` for one oscillator clock per period. All ratio inputs come from a latch outside the block. The block copies them into its counters only at a cycle boundary, so values that change during a cycle cannot corrupt the cycle that is running.

The feedback sequencer is a state machine with three states:
- `PH_IDLE` is the state after reset. The first prescaler output moves it to `PH_SWALLOW` when A ≠ 0 and to `PH_MAIN` when A = 0.
- In `PH_SWALLOW` the prescaler divides by M+1. The state moves to `PH_MAIN` when the swallow count runs out.
- In `PH_MAIN` the prescaler divides by M. When the main count reaches its last period, the block issues the pulse and reloads. It then re-enters `PH_SWALLOW`, or stays in `PH_MAIN` when the new A is 0.

Top module: `fbdiv_top`

## Requirements
- R1: The number of `vco_clk` cycles from one `fb_pulse` to the next equals M·N + A. Here N is `main_val` and A is `swallow_val`, both as they were when that cycle started.
- R2: `pre_sel` = 1 selects the modulus pair 64/65 (M = 64). `pre_sel` = 0 selects the pair 128/129 (M = 128).
- R3: When A = 0 the prescaler never uses the larger modulus, so the period is exactly M·N.
- R4: `fb_pulse` is high for exactly one `vco_clk` cycle per division cycle.
- R5: A change of `main_val`, `swallow_val` or `pre_sel` during a division cycle leaves that cycle's length unchanged. The new values set the length of the following cycle.
- R6: The legal ranges are handled at their extremes: N from 5 (11-bit field, up to 2047), A from 0 to 127 (7-bit field) with A < N. This includes N = 5 with A = 4, and A = 127.
- R7: `ref_pulse` is high for one `osc_clk` cycle every R `osc_clk` cycles. R is `ref_val`, a 14-bit field from 5 to 16383.
- R8: A change of `ref_val` during a reference period leaves that period unchanged. The new value sets the length of the next period.
- R9: While `rst_n` is low, both `fb_pulse` and `ref_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | VCO-rate clock being divided |
| osc_clk | input | 1 | Oscillator clock for the reference divider |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| pre_sel | input | 1 | Modulus pair select: 1 = 64/65, 0 = 128/129 |
| swallow_val | input | 7 | Swallow count A |
| main_val | input | 11 | Main count N |
| ref_val | input | 14 | Reference ratio R |
| fb_pulse | output | 1 | One-cycle pulse per feedback division cycle |
| ref_pulse | output | 1 | One-cycle pulse per reference period |

## Verification
A wrong swallow count or a bad state transition does not stay hidden. It shifts the pulse spacing by a multiple of one VCO clock per affected prescaler period, so the very next `fb_pulse` lands off its expected cycle. A prescaler modulus error, or a boundary capture that reads the inputs at the wrong time, shows up within one division cycle as a period that matches neither the old ratio nor the new one. The reference divider fails in the same way within a single R-length period.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_SWALLOW = 2'd1,
        PH_MAIN    = 2'd2
    } phase_e;

    localparam int MIN_COUNT = 5;

endpackage

// File: rtl/dm_prescaler.sv
module dm_prescaler #(
    parameter int LO_MOD = 64,
    parameter int HI_MOD = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lo_sel,
    input  logic mod_up,
    output logic tick
);
    localparam int CW = $clog2(HI_MOD + 1);
    localparam logic [CW-1:0] LO_TOP = CW'(LO_MOD - 1);
    localparam logic [CW-1:0] HI_TOP = CW'(HI_MOD - 1);
    localparam logic [CW-1:0] HI_LIM = CW'(HI_MOD);

    logic [CW-1:0] cnt;
    logic [CW-1:0] reload;

    always_comb begin
        reload = (lo_sel ? LO_TOP : HI_TOP) + {{(CW-1){1'b0}}, mod_up};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == '0) begin
            cnt <= reload;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assign tick = (cnt == '0);

    // R2: the count never exceeds the larger modulus minus one plus the swallow step
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= HI_LIM);

    // R1: a tick is always followed by a reload away from zero
    a_r1_tick_reload: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/swallow_fsm.sv
module swallow_fsm
    import fbdiv_pkg::*;
#(
    parameter int N_W = 11,
    parameter int A_W = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           sel_in,
    input  logic [A_W-1:0] a_in,
    input  logic [N_W-1:0] n_in,
    output logic           lo_sel_next,
    output logic           mod_up_next,
    output logic           fp
);
    localparam logic [N_W-1:0] N_ONE = N_W'(1);
    localparam logic [A_W-1:0] A_ONE = A_W'(1);

    phase_e         phase, phase_n;
    logic [A_W-1:0] sw_left, sw_n;
    logic [N_W-1:0] main_left, main_n;
    logic           sel_q, sel_n;
    logic           fp_n;
    logic           load;

    always_comb begin
        phase_n = phase;
        sw_n    = sw_left;
        main_n  = main_left;
        sel_n   = sel_q;
        fp_n    = 1'b0;
        load    = 1'b0;
        if (tick) begin
            unique case (phase)
                PH_IDLE: begin
                    load = 1'b1;
                end
                PH_SWALLOW: begin
                    if (main_left == N_ONE) begin
                        load = 1'b1;
                        fp_n = 1'b1;
                    end else begin
                        sw_n   = sw_left - 1'b1;
                        main_n = main_left - 1'b1;
                        if (sw_left == A_ONE) phase_n = PH_MAIN;
                    end
                end
                PH_MAIN: begin
                    if (main_left == N_ONE) begin
                        load = 1'b1;
                        fp_n = 1'b1;
                    end else begin
                        main_n = main_left - 1'b1;
                    end
                end
                default: load = 1'b1;
            endcase
            if (load) begin
                sw_n    = a_in;
                main_n  = n_in;
                sel_n   = sel_in;
                phase_n = (a_in == '0) ? PH_MAIN : PH_SWALLOW;
            end
        end
    end

    assign lo_sel_next = sel_n;
    assign mod_up_next = (phase_n == PH_SWALLOW);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            sw_left   <= '0;
            main_left <= '0;
            sel_q     <= 1'b0;
        end else begin
            phase     <= phase_n;
            sw_left   <= sw_n;
            main_left <= main_n;
            sel_q     <= sel_n;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fp <= 1'b0;
        end else begin
            fp <= fp_n;
        end
    end

    // R4: the comparison pulse lasts a single clock
    a_r4_fp_single: assert property (@(posedge clk) disable iff (!rst_n)
        fp |=> !fp);

    // R1: a pulse only follows a prescaler output
    a_r1_fp_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        fp |-> $past(tick));

    // R3: the swallow phase is never entered with nothing left to swallow
    a_r3_swallow_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SWALLOW) |-> (sw_left != '0));

    // R6: values captured at a boundary are legal
    a_r6_legal_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (n_in >= N_W'(MIN_COUNT) && N_W'(a_in) < n_in));

    // R5: between prescaler outputs the counters hold
    a_r5_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(main_left) && $stable(sel_q)));

endmodule

// File: rtl/ref_divider.sv
module ref_divider
    import fbdiv_pkg::*;
#(
    parameter int R_W = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [R_W-1:0] r_in,
    output logic           fr
);
    logic [R_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            fr  <= 1'b0;
        end else if (cnt == '0) begin
            cnt <= r_in - 1'b1;
            fr  <= 1'b1;
        end else begin
            cnt <= cnt - 1'b1;
            fr  <= 1'b0;
        end
    end

    // R7: the reference pulse lasts a single clock
    a_r7_fr_single: assert property (@(posedge clk) disable iff (!rst_n)
        fr |=> !fr);

    // R7: reload values are legal
    a_r7_legal_ratio: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> (r_in >= R_W'(MIN_COUNT)));

endmodule

// File: rtl/fbdiv_top.sv
module fbdiv_top #(
    parameter int N_W    = 11,
    parameter int A_W    = 7,
    parameter int R_W    = 14,
    parameter int LO_MOD = 64,
    parameter int HI_MOD = 128
) (
    input  logic           vco_clk,
    input  logic           osc_clk,
    input  logic           rst_n,
    input  logic           pre_sel,
    input  logic [A_W-1:0] swallow_val,
    input  logic [N_W-1:0] main_val,
    input  logic [R_W-1:0] ref_val,
    output logic           fb_pulse,
    output logic           ref_pulse
);
    logic pre_tick;
    logic lo_sel_next;
    logic mod_up_next;

    dm_prescaler #(
        .LO_MOD (LO_MOD),
        .HI_MOD (HI_MOD)
    ) u_pre (
        .clk    (vco_clk),
        .rst_n  (rst_n),
        .lo_sel (lo_sel_next),
        .mod_up (mod_up_next),
        .tick   (pre_tick)
    );

    swallow_fsm #(
        .N_W (N_W),
        .A_W (A_W)
    ) u_seq (
        .clk         (vco_clk),
        .rst_n       (rst_n),
        .tick        (pre_tick),
        .sel_in      (pre_sel),
        .a_in        (swallow_val),
        .n_in        (main_val),
        .lo_sel_next (lo_sel_next),
        .mod_up_next (mod_up_next),
        .fp          (fb_pulse)
    );

    ref_divider #(
        .R_W (R_W)
    ) u_ref (
        .clk   (osc_clk),
        .rst_n (rst_n),
        .r_in  (ref_val),
        .fr    (ref_pulse)
    );

    // R9: no pulses while reset is held
    always_comb begin
        if (!rst_n) begin
            a_r9_quiet_in_reset: assert (!fb_pulse && !ref_pulse);
        end
    end

endmodule

// File: tb/test_fbdiv_top.sv
module test_fbdiv_top;

    logic        vco_clk = 1'b0;
    logic        osc_clk = 1'b0;
    logic        rst_n   = 1'b0;
    logic        pre_sel = 1'b1;
    logic [6:0]  swallow_val = 7'd3;
    logic [10:0] main_val    = 11'd10;
    logic [13:0] ref_val     = 14'd7;
    logic        fb_pulse;
    logic        ref_pulse;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 vco_clk = ~vco_clk;
    initial begin
        #2;
        forever #4 osc_clk = ~osc_clk;
    end

    fbdiv_top i_fbdiv_top (
        .vco_clk     (vco_clk),
        .osc_clk     (osc_clk),
        .rst_n       (rst_n),
        .pre_sel     (pre_sel),
        .swallow_val (swallow_val),
        .main_val    (main_val),
        .ref_val     (ref_val),
        .fb_pulse    (fb_pulse),
        .ref_pulse   (ref_pulse)
    );

    function automatic int exp_ratio(input bit sel, input int n, input int a);
        return (sel ? 64 : 128) * n + a;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // waits for the next fb_pulse, then counts clocks to the following one
    task automatic measure_fb(output int period, output bit wide);
        wide = 1'b0;
        do @(negedge vco_clk); while (!fb_pulse);
        period = 0;
        @(negedge vco_clk);
        period++;
        if (fb_pulse) wide = 1'b1;
        while (!fb_pulse) begin
            @(negedge vco_clk);
            period++;
        end
    endtask

    task automatic measure_fr(output int period);
        do @(negedge osc_clk); while (!ref_pulse);
        period = 0;
        do begin
            @(negedge osc_clk);
            period++;
        end while (!ref_pulse);
    endtask

    task automatic run_fb(input bit sel, input int n, input int a, input string req);
        int p;
        bit w;
        pre_sel     = sel;
        main_val    = 11'(n);
        swallow_val = 7'(a);
        measure_fb(p, w);
        check(p == exp_ratio(sel, n, a), req, p, exp_ratio(sel, n, a));
    endtask

    initial begin
        int p;
        bit w;
        int n;
        int a;
        bit s;
        void'($urandom(32'd8191));

        // R9: reset state
        repeat (3) @(negedge vco_clk);
        check(!fb_pulse, "R9 fb_pulse in reset", int'(fb_pulse), 0);
        check(!ref_pulse, "R9 ref_pulse in reset", int'(ref_pulse), 0);
        rst_n = 1'b1;

        // R1 R2: first setting, 64/65 pair
        measure_fb(p, w);
        check(p == exp_ratio(1'b1, 10, 3), "R1 R2 sel=1 period", p, exp_ratio(1'b1, 10, 3));
        // R4: pulse width
        check(!w, "R4 fb_pulse single cycle", int'(w), 0);

        // R2: 128/129 pair
        run_fb(1'b0, 9, 5, "R2 sel=0 period");
        // R3: zero swallow
        run_fb(1'b1, 7, 0, "R3 A=0 sel=1");
        run_fb(1'b0, 6, 0, "R3 A=0 sel=0");
        // R6: boundaries
        run_fb(1'b1, 5, 0, "R6 N=5 A=0");
        run_fb(1'b1, 5, 4, "R6 N=5 A=4");
        run_fb(1'b1, 128, 127, "R6 A=127");
        run_fb(1'b0, 5, 4, "R6 N=5 A=4 sel=0");

        // R5: change in the middle of a cycle
        pre_sel = 1'b1; main_val = 11'd8; swallow_val = 7'd2;
        measure_fb(p, w);
        do @(negedge vco_clk); while (!fb_pulse);
        p = 0;
        repeat (40) begin
            @(negedge vco_clk);
            p++;
        end
        pre_sel = 1'b0; main_val = 11'd11; swallow_val = 7'd9;
        while (!fb_pulse) begin
            @(negedge vco_clk);
            p++;
        end
        check(p == exp_ratio(1'b1, 8, 2), "R5 mid-cycle change ignored", p, exp_ratio(1'b1, 8, 2));
        p = 0;
        do begin
            @(negedge vco_clk);
            p++;
        end while (!fb_pulse);
        check(p == exp_ratio(1'b0, 11, 9), "R5 new values next cycle", p, exp_ratio(1'b0, 11, 9));

        // R1: randomized legal settings
        for (int i = 0; i < 10; i++) begin
            s = 1'($urandom);
            n = 5 + int'($urandom % 56);
            a = int'($urandom % n);
            run_fb(s, n, a, "R1 random setting");
            measure_fb(p, w);
            check(!w, "R4 random pulse width", int'(w), 0);
            check(p == exp_ratio(s, n, a), "R1 repeat period", p, exp_ratio(s, n, a));
        end

        // R7: reference divider
        measure_fr(p);
        check(p == 7, "R7 initial R=7", p, 7);
        ref_val = 14'd5;
        measure_fr(p);
        check(p == 5, "R7 R=5", p, 5);
        ref_val = 14'(37 + ($urandom % 200));
        n = int'(ref_val);
        measure_fr(p);
        check(p == n, "R7 random R", p, n);

        // R8: mid-period change
        ref_val = 14'd20;
        measure_fr(p);
        do @(negedge osc_clk); while (!ref_pulse);
        p = 0;
        repeat (6) begin
            @(negedge osc_clk);
            p++;
        end
        ref_val = 14'd9;
        while (!ref_pulse) begin
            @(negedge osc_clk);
            p++;
        end
        check(p == 20, "R8 mid-period change ignored", p, 20);
        measure_fr(p);
        check(p == 9, "R8 new R next period", p, 9);

        // R7: largest ratio
        ref_val = 14'd16383;
        measure_fr(p);
        check(p == 16383, "R7 R=16383", p, 16383);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge vco_clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule